// File: doc/BRIEF.md
# On/Off Time PWM Generator

This block produces one pulse-width-modulated output. The waveform is not set by a period and a compare level. Two independent durations set it instead: a high-phase count and a low-phase count. Each count is measured in ticks of an oscillator-enable strobe that pulses at 1 MHz, so one count is one microsecond. The period is the sum of the two counts.

Software sets up the generator through a byte-wide register port. Each 16-bit duration is split over two byte registers, with the low byte at the lower address. Writes land in shadow registers. The active counts pick up the shadow values only at the start of a period, so a change never cuts a phase short. A control register holds:

- an enable;
- a one-shot mode bit, which gives exactly one high/low cycle;
- a gate bit, which ANDs the output with an external input.

A separate global register holds the oscillator enable. The generator runs only while both the PWM enable and the oscillator enable are set. Clearing either one pulls the output low at once.

Register map (addresses 0 to 6, 3-bit address):

| Address | Contents |
|---|---|
| 0 | high-phase count, low byte |
| 1 | high-phase count, high byte |
| 2 | low-phase count, low byte |
| 3 | low-phase count, high byte |
| 4 | control: bit 0 enable, bit 1 one-shot (0 means continuous), bit 2 gate |
| 5 | global: bit 0 oscillator enable |
| 6 | status, read only: bit 0 busy, bit 1 current phase level |

Top module: `pwm_onoff`

## Requirements
- R1: After reset, every register reads 0, the output is low and the busy status bit is 0.
- R2: Registers 0 to 5 read back the value last written. Register 6 is read only, and a write to it leaves its contents unchanged. Unmapped addresses read 0.
- R3: In continuous mode, the cycle after the write that starts the generator begins a high phase of ON ticks. It is followed by a low phase of OFF ticks, and this repeats with a period of ON+OFF ticks.
- R4: An ON count of zero keeps the output low. An OFF count of zero with a nonzero ON count keeps the output high.
- R5: Clearing the enable bit drives the output low in the cycle right after the write lands, mid-period if need be, and clears busy.
- R6: With the oscillator enable at 0, setting the PWM enable leaves the output low and busy at 0.
- R7: Phase counters advance only on clock cycles where tick is high. With tick held low, the current phase and level hold.
- R8: Duration writes made during a period do not alter that period. The new counts take effect from the next period start.
- R9: In one-shot mode (control bit 1 set), the generator produces exactly one high/low cycle. It then holds the output low and clears busy until it is disabled and enabled again.
- R10: With the gate bit set, the output is the generated level ANDed with ext_in. With the gate bit clear, ext_in has no effect.
- R11: Durations use the full 16 bits, with the high byte at the odd address weighting 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one pulse per microsecond |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte for addr (combinational) |
| ext_in | input | 1 | External gating input |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets the zero-count corners:

- An ON count of zero: a design that entered the high phase anyway would emit a one-tick glitch every period.
- An OFF count of zero: a design that treated it as 65536 would drop low for a long stretch.

It rewrites the durations in the middle of a period. A design without shadowing would shorten or stretch that period. It checks that a disable mid-high-phase falls in the very next cycle, not at the period end. It also checks that one-shot mode stops after a single cycle instead of reloading.

A 16-bit ON count above 255 catches a swapped or ignored high byte. Holding tick low catches a counter that runs on the raw clock.

// File: rtl/pwm_onoff_pkg.sv
package pwm_onoff_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // control register bit positions
    localparam int unsigned CTL_EN      = 0;
    localparam int unsigned CTL_ONESHOT = 1;
    localparam int unsigned CTL_GATE    = 2;
    // global register bit positions
    localparam int unsigned GLB_OSC     = 0;
    // status register bit positions
    localparam int unsigned STS_BUSY    = 0;
    localparam int unsigned STS_LEVEL   = 1;

endpackage

// File: rtl/pwm_onoff_regs.sv
module pwm_onoff_regs
    import pwm_onoff_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CNT_BYTES = 2,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         sts_busy,
    input  logic                         sts_level,
    output logic [DATA_W*CNT_BYTES-1:0]  sh_on,
    output logic [DATA_W*CNT_BYTES-1:0]  sh_off,
    output logic                         cfg_en,
    output logic                         cfg_oneshot,
    output logic                         cfg_gate,
    output logic                         cfg_osc
);

    localparam int unsigned CNT_W    = DATA_W * CNT_BYTES;
    localparam int unsigned A_ON     = 0;
    localparam int unsigned A_OFF    = CNT_BYTES;
    localparam int unsigned A_CTL    = 2 * CNT_BYTES;
    localparam int unsigned A_GLB    = 2 * CNT_BYTES + 1;
    localparam int unsigned A_STS    = 2 * CNT_BYTES + 2;

    typedef struct packed {
        logic [CNT_W-1:0]  on_cnt;
        logic [CNT_W-1:0]  off_cnt;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] glb;
    } regs_t;

    regs_t r_d, r_q;
    logic [DATA_W-1:0] sts_byte;

    always_comb begin
        sts_byte            = '0;
        sts_byte[STS_BUSY]  = sts_busy;
        sts_byte[STS_LEVEL] = sts_level;
    end

    // next-state: byte lanes of each duration, then control and global
    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int b = 0; b < int'(CNT_BYTES); b++) begin
                if (addr == ADDR_W'(A_ON + b))
                    r_d.on_cnt[b*DATA_W +: DATA_W] = wr_data;
                if (addr == ADDR_W'(A_OFF + b))
                    r_d.off_cnt[b*DATA_W +: DATA_W] = wr_data;
            end
            if (addr == ADDR_W'(A_CTL)) begin
                r_d.ctl                = '0;
                r_d.ctl[CTL_EN]        = wr_data[CTL_EN];
                r_d.ctl[CTL_ONESHOT]   = wr_data[CTL_ONESHOT];
                r_d.ctl[CTL_GATE]      = wr_data[CTL_GATE];
            end
            if (addr == ADDR_W'(A_GLB)) begin
                r_d.glb          = '0;
                r_d.glb[GLB_OSC] = wr_data[GLB_OSC];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < int'(CNT_BYTES); b++) begin
            if (addr == ADDR_W'(A_ON + b))  rd_data = r_q.on_cnt[b*DATA_W +: DATA_W];
            if (addr == ADDR_W'(A_OFF + b)) rd_data = r_q.off_cnt[b*DATA_W +: DATA_W];
        end
        if (addr == ADDR_W'(A_CTL)) rd_data = r_q.ctl;
        if (addr == ADDR_W'(A_GLB)) rd_data = r_q.glb;
        if (addr == ADDR_W'(A_STS)) rd_data = sts_byte;
    end

    assign sh_on       = r_q.on_cnt;
    assign sh_off      = r_q.off_cnt;
    assign cfg_en      = r_q.ctl[CTL_EN];
    assign cfg_oneshot = r_q.ctl[CTL_ONESHOT];
    assign cfg_gate    = r_q.ctl[CTL_GATE];
    assign cfg_osc     = r_q.glb[GLB_OSC];

endmodule

// File: rtl/pwm_onoff_core.sv
module pwm_onoff_core
    import pwm_onoff_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] sh_on,
    input  logic [CNT_W-1:0] sh_off,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_on,
    output logic             load
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] aon;
        logic [CNT_W-1:0] aoff;
    } core_t;

    core_t c_d, c_q;
    logic  period_end;
    logic  load_d;

    always_comb begin
        c_d        = c_q;
        period_end = 1'b0;
        load_d     = 1'b0;
        if (!run) begin
            c_d.ph  = PH_IDLE;
            c_d.cnt = '0;
        end else begin
            unique case (c_q.ph)
                PH_IDLE: load_d = 1'b1;
                PH_HIGH: begin
                    if (tick) begin
                        if (c_q.cnt == c_q.aon - ONE) begin
                            if (c_q.aoff != '0) begin
                                c_d.ph  = PH_LOW;
                                c_d.cnt = '0;
                            end else begin
                                period_end = 1'b1;
                            end
                        end else begin
                            c_d.cnt = c_q.cnt + ONE;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (c_q.aoff == '0 || c_q.cnt == c_q.aoff - ONE)
                            period_end = 1'b1;
                        else
                            c_d.cnt = c_q.cnt + ONE;
                    end
                end
                PH_DONE: ;
                default: c_d.ph = PH_IDLE;
            endcase
            if (period_end) begin
                if (oneshot) begin
                    c_d.ph  = PH_DONE;
                    c_d.cnt = '0;
                end else begin
                    load_d = 1'b1;
                end
            end
            // period start: copy shadow durations into the active pair
            if (load_d) begin
                c_d.aon  = sh_on;
                c_d.aoff = sh_off;
                c_d.cnt  = '0;
                c_d.ph   = (sh_on != '0) ? PH_HIGH : PH_LOW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, cnt: '0, aon: '0, aoff: '0};
        else        c_q <= c_d;
    end

    assign phase  = c_q.ph;
    assign cnt    = c_q.cnt;
    assign act_on = c_q.aon;
    assign load   = load_d;

endmodule

// File: rtl/pwm_onoff_gate.sv
module pwm_onoff_gate
    import pwm_onoff_pkg::*;
(
    input  phase_e phase,
    input  logic   run,
    input  logic   gate_en,
    input  logic   ext_in,
    output logic   level,
    output logic   busy,
    output logic   out
);

    always_comb begin
        level = (phase == PH_HIGH);
        busy  = (phase == PH_HIGH) || (phase == PH_LOW);
        // run is applied here so a disable reaches the pin without waiting
        out   = level && run && (!gate_en || ext_in);
    end

endmodule

// File: rtl/pwm_onoff.sv
module pwm_onoff
    import pwm_onoff_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CNT_BYTES = 2,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_in,
    output logic              pwm_out
);

    localparam int unsigned CNT_W = DATA_W * CNT_BYTES;

    logic [CNT_W-1:0] sh_on, sh_off, cnt, act_on;
    logic             cfg_en, cfg_oneshot, cfg_gate, cfg_osc;
    logic             run, level, busy, load;
    phase_e           phase;

    assign run = cfg_en && cfg_osc;

    pwm_onoff_regs #(
        .DATA_W    (DATA_W),
        .CNT_BYTES (CNT_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .sts_busy    (busy),
        .sts_level   (level),
        .sh_on       (sh_on),
        .sh_off      (sh_off),
        .cfg_en      (cfg_en),
        .cfg_oneshot (cfg_oneshot),
        .cfg_gate    (cfg_gate),
        .cfg_osc     (cfg_osc)
    );

    pwm_onoff_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .oneshot (cfg_oneshot),
        .sh_on   (sh_on),
        .sh_off  (sh_off),
        .phase   (phase),
        .cnt     (cnt),
        .act_on  (act_on),
        .load    (load)
    );

    pwm_onoff_gate u_gate (
        .phase   (phase),
        .run     (run),
        .gate_en (cfg_gate),
        .ext_in  (ext_in),
        .level   (level),
        .busy    (busy),
        .out     (pwm_out)
    );

endmodule

// File: rtl/pwm_onoff_chk.sv
module pwm_onoff_chk
    import pwm_onoff_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ext_in,
    input logic             pwm_out,
    input logic             run,
    input logic             gate,
    input logic             busy,
    input logic             load,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_on
);

    // R5
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);

    // R6
    stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !busy);

    // R10
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !ext_in) |-> !pwm_out);

    // R4
    high_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) |-> (act_on != '0));

    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && busy) |=> ($stable(cnt) && $stable(phase)));

    // R8
    active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_on) |-> $past(load));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && run) |=> (phase == PH_DONE && !pwm_out));

endmodule

bind pwm_onoff pwm_onoff_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ext_in  (ext_in),
    .pwm_out (pwm_out),
    .run     (run),
    .gate    (cfg_gate),
    .busy    (busy),
    .load    (load),
    .phase   (phase),
    .cnt     (cnt),
    .act_on  (act_on)
);

// File: tb/pwm_onoff_tb.sv
`timescale 1ns/100ps
module pwm_onoff_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_hold = 1'b0;
    logic       tick;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ext_in = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic hist [1024];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    assign tick = ~tick_hold;

    pwm_onoff u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ext_in(ext_in), .pwm_out(pwm_out)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        #1;
        hist[cyc % 1024] = pwm_out;
    end

    typedef struct packed {
        logic [15:0] on;
        logic [15:0] off;
        logic        os;
        logic        gate;
        logic        ext;
        logic [15:0] win;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{16'd3,   16'd5, 1'b0, 1'b0, 1'b0, 16'd40},  // R3
        '{16'd1,   16'd1, 1'b0, 1'b0, 1'b0, 16'd20},  // R3
        '{16'd0,   16'd4, 1'b0, 1'b0, 1'b0, 16'd20},  // R4
        '{16'd4,   16'd0, 1'b0, 1'b0, 1'b0, 16'd20},  // R4
        '{16'd2,   16'd3, 1'b1, 1'b0, 1'b0, 16'd30},  // R9
        '{16'd3,   16'd2, 1'b0, 1'b1, 1'b0, 16'd20},  // R10
        '{16'd3,   16'd2, 1'b0, 1'b1, 1'b1, 16'd20},  // R10
        '{16'd261, 16'd3, 1'b1, 1'b0, 1'b0, 16'd280}, // R11
        '{16'd0,   16'd0, 1'b0, 1'b0, 1'b0, 16'd12}   // R4
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic bit exp_lvl(input int k, input int on, input int off, input bit os);
        if (on == 0)  return 1'b0;
        if (os)       return k < on;
        return (k % (on + off)) < on;
    endfunction

    // program durations, oscillator and control; returns write-landing cycle
    task automatic start(input int on, input int off, input bit osc,
                         input logic [7:0] ctl, output int en_cyc);
        wr(3'd4, 8'h00);
        wr(3'd0, on[7:0]);
        wr(3'd1, on[15:8]);
        wr(3'd2, off[7:0]);
        wr(3'd3, off[15:8]);
        wr(3'd5, {7'd0, osc});
        wr(3'd4, ctl);
        en_cyc = cyc;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int en_cyc;
        int bad;
        int first_k;
        int lows;

        waitn(3);
        rst_n = 1'b1;
        waitn(2);

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], d);
            chk(d == 8'h00, $sformatf("R1 reg %0d after reset", a), d, 0);
        end
        chk(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);

        // R2 / R11: readback, little-endian bytes, read-only status
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        wr(3'd4, 8'h06);
        rd(3'd0, d); chk(d == 8'h34, "R2 on low byte readback", d, 8'h34);
        rd(3'd1, d); chk(d == 8'h12, "R11 on high byte readback", d, 8'h12);
        rd(3'd4, d); chk(d == 8'h06, "R2 control readback", d, 8'h06);
        wr(3'd6, 8'hFF);
        rd(3'd6, d); chk(d == 8'h00, "R2 status write ignored", d, 0);
        rd(3'd7, d); chk(d == 8'h00, "R2 unmapped address", d, 0);

        // vector walk: R3 R4 R9 R10 R11
        for (int v = 0; v < 9; v++) begin
            ext_in = VEC[v].ext;
            start(VEC[v].on, VEC[v].off, 1'b1,
                  {5'd0, VEC[v].gate, VEC[v].os, 1'b1}, en_cyc);
            waitn(int'(VEC[v].win) + 2);
            bad = 0; first_k = -1;
            for (int k = 0; k < int'(VEC[v].win); k++) begin
                bit e;
                e = exp_lvl(k, VEC[v].on, VEC[v].off, VEC[v].os) &&
                    (!VEC[v].gate || VEC[v].ext);
                if (hist[(en_cyc + 1 + k) % 1024] !== e) begin
                    bad++;
                    if (first_k < 0) first_k = k;
                end
            end
            chk(bad == 0, $sformatf("R3/R4/R9/R10/R11 vector %0d waveform (mismatch count, first at %0d)",
                v, first_k), bad, 0);
            rd(3'd6, d);
            chk(d[0] == !VEC[v].os, $sformatf("R3/R9 vector %0d busy after window", v),
                d[0], !VEC[v].os);
        end
        ext_in = 1'b0;

        // R8: shadow durations change only at the next period start
        start(8, 8, 1'b1, 8'h01, en_cyc);
        wr(3'd0, 8'd2);
        wr(3'd2, 8'd3);
        waitn(45);
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            bit e;
            e = (k < 16) ? exp_lvl(k, 8, 8, 1'b0) : exp_lvl(k - 16, 2, 3, 1'b0);
            if (hist[(en_cyc + 1 + k) % 1024] !== e) bad++;
        end
        chk(bad == 0, "R8 shadow update at period boundary (mismatch count)", bad, 0);

        // R7: without tick the high phase holds
        tick_hold = 1'b1;
        start(3, 2, 1'b1, 8'h01, en_cyc);
        waitn(22);
        bad = 0;
        for (int k = 0; k < 20; k++)
            if (hist[(en_cyc + 1 + k) % 1024] !== 1'b1) bad++;
        chk(bad == 0, "R7 level holds with tick low (mismatch count)", bad, 0);
        tick_hold = 1'b0;
        waitn(12);
        lows = 0;
        for (int k = 22; k < 32; k++)
            if (hist[(en_cyc + 1 + k) % 1024] === 1'b0) lows++;
        chk(lows == 4, "R7 phases resume when tick returns (low cycles)", lows, 4);

        // R6: oscillator enable required
        start(3, 3, 1'b0, 8'h01, en_cyc);
        waitn(12);
        bad = 0;
        for (int k = 0; k < 10; k++)
            if (hist[(en_cyc + 1 + k) % 1024] !== 1'b0) bad++;
        chk(bad == 0, "R6 output low without oscillator (high count)", bad, 0);
        rd(3'd6, d);
        chk(d[0] == 1'b0, "R6 busy low without oscillator", d[0], 0);

        // R5: disable mid-high-phase drops output at once
        start(10, 10, 1'b1, 8'h01, en_cyc);
        waitn(3);
        chk(pwm_out == 1'b1, "R5 output high before disable", pwm_out, 1);
        wr(3'd4, 8'h00);
        chk(pwm_out == 1'b0, "R5 output low right after disable", pwm_out, 0);
        rd(3'd6, d);
        chk(d[0] == 1'b0, "R5 busy cleared after disable", d[0], 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule